// File: doc/BRIEF.md
# DDR3 Command Spacing Checker

This block sits beside a memory channel and watches an already decoded stream of DDR3 commands, at most one per clock, each tagged with its type, rank and bank. It never drives the bus. For every incoming command it measures how many clocks have passed since the relevant earlier command and compares that distance against a programmable minimum. When a command arrives too early, the block reports which rule was broken, where it was broken, and by what distance.

Four spacing rules are watched:
- read followed by precharge on the same bank;
- write followed by read on the same rank;
- write followed by precharge on the same bank;
- the quiet period after a short calibration command, during which no command of any kind may appear on the channel.

All banks of all ranks are tracked at once with independent saturating timers. Each rule can be switched off on its own, and its minimum is a plain input that the system holds steady while traffic flows.

Top module: `ddr_spacing_checker`

## Requirements
- R1: Coming out of reset, `viol_valid` is 0. Every timer starts saturated, so the first command to reach any bank or rank after reset is never flagged.
- R2: Command codes are 3'd1 ACTIVATE, 3'd2 READ, 3'd3 WRITE, 3'd4 PRECHARGE and 3'd5 short calibration; any other code is a plain command. A PRECHARGE is flagged with rule code 0 when its distance from the last READ to the same rank and bank is less than `min_rd2pre`. With a minimum of 8, a distance of 7 is flagged.
- R3: A READ is flagged with rule code 1 when its distance from the last WRITE to the same rank, to any bank, is less than `min_wr2rd`. With a minimum of 20, a distance of 19 is flagged.
- R4: A PRECHARGE is flagged with rule code 2 when its distance from the last WRITE to the same rank and bank is less than `min_wr2pre`.
- R5: Any command is flagged with rule code 3 when its distance from the last calibration command on the channel, whatever its rank, is less than `min_zq`.
- R6: A distance equal to or greater than a rule's minimum never produces a report for that rule.
- R7: Timers are independent. A reference on one bank or rank has no effect on a command sent to a different bank or rank.
- R8: Bit k of `rule_en` enables rule code k. When that bit is 0, the rule never reports.
- R9: The distance is the difference between the two commands' clock indices, so back-to-back commands have a distance of 1. A report appears on the clock after the offending command. It holds `viol_valid` high for exactly one clock and carries that command's rank and bank together with the measured distance in `viol_gap`.
- R10: When several rules fire on the same command, only one is reported: the rule with the highest code.
- R11: Timers saturate at 2^CNT_W-1 instead of wrapping. An arbitrarily long distance therefore reads as that maximum value and cannot trip a rule whose minimum is no larger than it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this clock |
| cmd_op | input | 3 | Command code |
| cmd_rank | input | RANK_W | Rank of the command |
| cmd_bank | input | BANK_W | Bank of the command |
| rule_en | input | 4 | Per-rule enable, bit k for rule code k |
| min_rd2pre | input | CNT_W | Minimum distance from read to precharge, same bank |
| min_wr2rd | input | CNT_W | Minimum distance from write to read, same rank |
| min_wr2pre | input | CNT_W | Minimum distance from write to precharge, same bank |
| min_zq | input | CNT_W | Channel quiet period after calibration |
| viol_valid | output | 1 | One-clock violation report |
| viol_rule | output | 2 | Code of the reported rule |
| viol_rank | output | RANK_W | Rank of the offending command |
| viol_bank | output | BANK_W | Bank of the offending command |
| viol_gap | output | CNT_W | Measured distance in clocks |

## Verification
The bench probes each rule exactly at its minimum and one clock below it. An off-by-one comparison would either miss the 7-clock read-to-precharge gap or flag the legal 20-clock write-to-read gap.

A single precharge is sent that breaks two bank rules at once. This catches a design that reports the wrong code or mixes one rule's distance with another rule's code. Commands to neighbouring banks and ranks expose timers that are shared when they should be separate.

A 300-clock distance against a minimum of 255 catches a timer that wraps instead of saturating. Without saturation the timer would read 44 and raise a false report.

// File: rtl/ddr_spacing_checker.sv
module ddr_spacing_checker #(
  parameter int RANK_W = 1,
  parameter int BANK_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [3:0]        rule_en,
  input  logic [CNT_W-1:0]  min_rd2pre,
  input  logic [CNT_W-1:0]  min_wr2rd,
  input  logic [CNT_W-1:0]  min_wr2pre,
  input  logic [CNT_W-1:0]  min_zq,
  output logic              viol_valid,
  output logic [1:0]        viol_rule,
  output logic [RANK_W-1:0] viol_rank,
  output logic [BANK_W-1:0] viol_bank,
  output logic [CNT_W-1:0]  viol_gap
);
  localparam int SLOT_W = RANK_W + BANK_W;
  localparam int NRANK  = 1 << RANK_W;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [2:0] OP_RD = 3'd2, OP_WR = 3'd3, OP_PRE = 3'd4, OP_ZQ = 3'd5;

  logic [CNT_W-1:0] rd_t  [NSLOT];
  logic [CNT_W-1:0] wrb_t [NSLOT];
  logic [CNT_W-1:0] wrr_t [NRANK];
  logic [CNT_W-1:0] zq_t;

  wire [SLOT_W-1:0] slot = {cmd_rank, cmd_bank};
  wire is_rd  = cmd_valid && cmd_op == OP_RD;
  wire is_wr  = cmd_valid && cmd_op == OP_WR;
  wire is_pre = cmd_valid && cmd_op == OP_PRE;
  wire is_zq  = cmd_valid && cmd_op == OP_ZQ;

  wire h_rp = rule_en[0] && is_pre && rd_t[slot] < min_rd2pre;
  wire h_wr = rule_en[1] && is_rd && wrr_t[cmd_rank] < min_wr2rd;
  wire h_wp = rule_en[2] && is_pre && wrb_t[slot] < min_wr2pre;
  wire h_zq = rule_en[3] && cmd_valid && zq_t < min_zq;

  function automatic logic [CNT_W-1:0] step(input logic hit, input logic [CNT_W-1:0] v);
    return hit ? CNT_W'(1) : (v == CMAX ? v : v + CNT_W'(1));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        rd_t[i]  <= CMAX;
        wrb_t[i] <= CMAX;
      end
      for (int r = 0; r < NRANK; r++) wrr_t[r] <= CMAX;
      zq_t       <= CMAX;
      viol_valid <= 1'b0;
      viol_rule  <= '0;
      viol_rank  <= '0;
      viol_bank  <= '0;
      viol_gap   <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        rd_t[i]  <= step(is_rd && slot == SLOT_W'(i), rd_t[i]);
        wrb_t[i] <= step(is_wr && slot == SLOT_W'(i), wrb_t[i]);
      end
      for (int r = 0; r < NRANK; r++)
        wrr_t[r] <= step(is_wr && cmd_rank == RANK_W'(r), wrr_t[r]);
      zq_t       <= step(is_zq, zq_t);
      viol_valid <= h_zq | h_wp | h_wr | h_rp;
      viol_rank  <= cmd_rank;
      viol_bank  <= cmd_bank;
      if (h_zq)      begin viol_rule <= 2'd3; viol_gap <= zq_t;             end
      else if (h_wp) begin viol_rule <= 2'd2; viol_gap <= wrb_t[slot];      end
      else if (h_wr) begin viol_rule <= 2'd1; viol_gap <= wrr_t[cmd_rank];  end
      else           begin viol_rule <= 2'd0; viol_gap <= rd_t[slot];       end
    end
  end

  a_r9_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(cmd_valid));
  a_r9_location: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> (viol_rank == $past(cmd_rank) && viol_bank == $past(cmd_bank)));
  a_r9_gap_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> viol_gap != '0);
  a_r2_on_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_rule == 2'd0) |-> $past(cmd_op) == OP_PRE);
  a_r3_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_rule == 2'd1) |-> $past(cmd_op) == OP_RD);
  a_r4_on_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_rule == 2'd2) |-> $past(cmd_op) == OP_PRE);
  a_r5_below_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_rule == 2'd3) |-> viol_gap < $past(min_zq));
  a_r8_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> ($past(rule_en) & (4'b0001 << viol_rule)) != 4'b0000);
endmodule

// File: tb/ddr_spacing_checker_tb_top.sv
module ddr_spacing_checker_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, cmd_valid;
  logic [2:0] cmd_op;
  logic [0:0] cmd_rank;
  logic [2:0] cmd_bank;
  logic [3:0] rule_en;
  logic [7:0] min_rd2pre, min_wr2rd, min_wr2pre, min_zq;
  logic       viol_valid;
  logic [1:0] viol_rule;
  logic [0:0] viol_rank;
  logic [2:0] viol_bank;
  logic [7:0] viol_gap;

  ddr_spacing_checker #(.RANK_W(1), .BANK_W(3), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .rule_en(rule_en),
    .min_rd2pre(min_rd2pre), .min_wr2rd(min_wr2rd), .min_wr2pre(min_wr2pre),
    .min_zq(min_zq), .viol_valid(viol_valid), .viol_rule(viol_rule),
    .viol_rank(viol_rank), .viol_bank(viol_bank), .viol_gap(viol_gap));

  typedef struct packed {
    logic [2:0] op; logic [0:0] rk; logic [2:0] bk;
    logic [7:0] wt; logic ev; logic [1:0] er; logic [7:0] eg;
  } vec_t;

  // op: 1 ACT, 2 RD, 3 WR, 4 PRE, 5 calibration; wt = idle clocks before the command
  localparam vec_t TBL [18] = '{
    '{3'd2, 1'd0, 3'd5, 8'd0,  1'b0, 2'd0, 8'd0},   // R1 first read after reset
    '{3'd4, 1'd0, 3'd5, 8'd6,  1'b1, 2'd0, 8'd7},   // R2 gap 7 < 8
    '{3'd2, 1'd0, 3'd5, 8'd0,  1'b0, 2'd0, 8'd0},
    '{3'd4, 1'd0, 3'd5, 8'd7,  1'b0, 2'd0, 8'd0},   // R6 gap 8
    '{3'd3, 1'd1, 3'd2, 8'd0,  1'b0, 2'd0, 8'd0},
    '{3'd2, 1'd1, 3'd0, 8'd18, 1'b1, 2'd1, 8'd19},  // R3 gap 19
    '{3'd2, 1'd0, 3'd0, 8'd0,  1'b0, 2'd0, 8'd0},   // R7 other rank
    '{3'd3, 1'd0, 3'd3, 8'd0,  1'b0, 2'd0, 8'd0},
    '{3'd2, 1'd0, 3'd1, 8'd19, 1'b0, 2'd0, 8'd0},   // R6 gap 20
    '{3'd4, 1'd0, 3'd3, 8'd3,  1'b1, 2'd2, 8'd24},  // R4 gap 24 < 26
    '{3'd4, 1'd0, 3'd4, 8'd0,  1'b0, 2'd0, 8'd0},   // R7 other bank
    '{3'd3, 1'd1, 3'd6, 8'd0,  1'b0, 2'd0, 8'd0},
    '{3'd2, 1'd1, 3'd6, 8'd0,  1'b1, 2'd1, 8'd1},   // R3 gap 1
    '{3'd4, 1'd1, 3'd6, 8'd2,  1'b1, 2'd2, 8'd4},   // R10 rules 0 and 2 both fire
    '{3'd5, 1'd0, 3'd0, 8'd0,  1'b0, 2'd0, 8'd0},
    '{3'd1, 1'd0, 3'd2, 8'd74, 1'b1, 2'd3, 8'd75},  // R5 gap 75 < 76
    '{3'd5, 1'd0, 3'd0, 8'd0,  1'b0, 2'd0, 8'd0},   // R6 gap 76
    '{3'd4, 1'd1, 3'd6, 8'd0,  1'b1, 2'd3, 8'd1}    // R5 gap 1
  };

  int checks = 0, errors = 0;

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";  1: return "R2";  3, 8, 16: return "R6";
      5, 12: return "R3";  6, 10: return "R7";  9: return "R4";
      13: return "R10";  15, 17: return "R5";  default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input bit ev, input int er, input int eg, input int erk, input int ebk);
    chk(viol_valid == ev, req, "viol_valid", viol_valid, ev);
    if (ev && viol_valid) begin
      chk(viol_rule == er, req, "viol_rule", viol_rule, er);
      chk(viol_gap == eg, req, "viol_gap", viol_gap, eg);
      chk(viol_rank == erk && viol_bank == ebk, req, "rank*8+bank",
          viol_rank * 8 + viol_bank, erk * 8 + ebk);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [0:0] rk, input logic [2:0] bk);
    cmd_valid = 1'b1; cmd_op = op; cmd_rank = rk; cmd_bank = bk;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cmd_op = '0; cmd_rank = '0; cmd_bank = '0;
    rule_en = 4'b1111;
    min_rd2pre = 8'd8; min_wr2rd = 8'd20; min_wr2pre = 8'd26; min_zq = 8'd76;
    @(negedge clk);
    do_reset();
    chk(viol_valid == 1'b0, "R1", "viol_valid after reset", viol_valid, 0);

    for (int i = 0; i < 18; i++) begin
      idle(int'(TBL[i].wt));
      issue(TBL[i].op, TBL[i].rk, TBL[i].bk);
      expect_out(tag_of(i), TBL[i].ev, int'(TBL[i].er), int'(TBL[i].eg),
                 int'(TBL[i].rk), int'(TBL[i].bk));
    end

    // R9: report lasts one clock
    idle(1);
    chk(viol_valid == 1'b0, "R9", "viol_valid one clock later", viol_valid, 0);

    // R1: reset mid-run clears the report and the timers
    do_reset();
    chk(viol_valid == 1'b0, "R1", "viol_valid after second reset", viol_valid, 0);
    issue(3'd4, 1'd1, 3'd6);
    expect_out("R1", 1'b0, 0, 0, 1, 6);

    // R8: rule 0 disabled, then enabled
    rule_en = 4'b1110;
    issue(3'd2, 1'd0, 3'd5);
    issue(3'd4, 1'd0, 3'd5);
    expect_out("R8", 1'b0, 0, 0, 0, 5);
    rule_en = 4'b1111;
    issue(3'd2, 1'd0, 3'd5);
    issue(3'd4, 1'd0, 3'd5);
    expect_out("R8", 1'b1, 0, 1, 0, 5);
    idle(1);
    chk(viol_valid == 1'b0, "R9", "pulse width", viol_valid, 0);

    // R11: saturation against a maximal minimum
    min_rd2pre = 8'd255;
    issue(3'd2, 1'd1, 3'd1);
    idle(299);
    issue(3'd4, 1'd1, 3'd1);
    expect_out("R11", 1'b0, 0, 0, 1, 1);
    issue(3'd2, 1'd1, 3'd1);
    idle(253);
    issue(3'd4, 1'd1, 3'd1);
    expect_out("R11", 1'b1, 0, 254, 1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule